// File: doc/BRIEF.md
# Strided Vector Update Engine

This engine applies one of four element-wise operations to signed fixed-point vectors held in a memory. It can copy X into Y, scale X and add it to Y, scale Y and add X to it, or multiply J by X element by element. Y is always the vector written, and the two update forms replace Y in place. Each vector has its own base address and element stride.

Three stages run at the same time. A fetch stage gathers one batch of LANES elements per operand vector. A compute stage turns the two operand batches into one result batch. A store stage writes that batch back to memory. While a batch is being stored, the next one can already be fetched. A vector with stride one is moved one memory word per access. A vector with any other stride is moved one element per access, and the fetch stage packs those elements into a batch. The host loads the operands, pulses `start`, and waits for `done`.

Top module: `vec_update_unit`

## Requirements
- R1: With `op` = 0, each Y[i] for i < `n` becomes X[i] unchanged.
- R2: With `op` = 1, Y[i] becomes sat(rnd(alpha·X[i]) + Y[i]).
- R3: With `op` = 2, Y[i] becomes sat(rnd(alpha·Y[i]) + X[i]).
- R4: With `op` = 3, Y[i] becomes rnd(J[i]·X[i]).
- R5: Values are signed with FRAC fractional bits. A product is rounded to nearest, with exact halves rounded toward plus infinity, and then clamped to the element range. A sum is also clamped to the element range. With FRAC = 8, 3·128 gives 2 and −3·128 gives −1.
- R6: An operand vector with stride 1 is read with one wide access per batch (`rd_wide` = 1). Any other stride uses one single-element access per element, with the element in lane 0. Writes to Y follow the same rule.
- R7: A wide write sets `wr_be` only for lanes that hold elements below `n`. A single-element write sets only bit 0. No memory location outside the n Y positions changes.
- R8: `done` goes low at `start`. When `n` > 0, `done` rises only after the last write has been accepted. When `n` = 0, `done` rises on the cycle after `start` and no access is made. When `busy` is low, no request is raised.
- R9: A request stays raised with stable address, data and enables until it is acknowledged. Read data is taken on `rd_rvalid` after any latency, so the results do not depend on how long the memory stalls.
- R10: After reset, `busy`, `done`, `rd_req` and `wr_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation with the current settings |
| op | input | 2 | 0 copy, 1 scaled-X add, 2 scaled-Y add, 3 element multiply |
| n | input | NW | Element count |
| alpha | input | EW | Scale factor, signed fixed point |
| base_x | input | AW | Element address of X[0] |
| base_y | input | AW | Element address of Y[0] |
| base_j | input | AW | Element address of J[0] |
| stride_x | input | AW | Element stride of X (at least 1) |
| stride_y | input | AW | Element stride of Y (at least 1) |
| stride_j | input | AW | Element stride of J (at least 1) |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | The last operation has completed |
| rd_req | output | 1 | Read request |
| rd_wide | output | 1 | 1: LANES consecutive elements; 0: one element |
| rd_addr | output | AW | Element address of the read |
| rd_ack | input | 1 | Read request accepted |
| rd_rvalid | input | 1 | Read data valid |
| rd_rdata | input | EW*LANES | Read data, lane k holds element addr+k |
| wr_req | output | 1 | Write request |
| wr_wide | output | 1 | 1: lanes map to consecutive elements; 0: lane 0 only |
| wr_addr | output | AW | Element address of the write |
| wr_data | output | EW*LANES | Write data |
| wr_be | output | LANES | Per-lane write enables |
| wr_ack | input | 1 | Write request accepted |

## Verification
The bench builds the engine with 16-bit elements, 4 lanes and 8 fractional bits. With only four lanes, counts up to twenty already cover full batches, ragged last batches and single-element runs, on both the wide path and the gather path. The 8.8 format lets ordinary random operands and scale factors reach the clamp limits and exact rounding halves. A memory model with random acknowledge delays and random read latency stresses the hold and stall rules, and the bench counts wide and single-element accesses against the totals that the strides predict.

// File: rtl/vec_update_unit.sv
module vec_update_unit #(
  parameter int EW    = 16,
  parameter int LANES = 4,
  parameter int FRAC  = 8,
  parameter int AW    = 16,
  parameter int NW    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [1:0]          op,
  input  logic [NW-1:0]       n,
  input  logic [EW-1:0]       alpha,
  input  logic [AW-1:0]       base_x,
  input  logic [AW-1:0]       base_y,
  input  logic [AW-1:0]       base_j,
  input  logic [AW-1:0]       stride_x,
  input  logic [AW-1:0]       stride_y,
  input  logic [AW-1:0]       stride_j,
  output logic                busy,
  output logic                done,
  output logic                rd_req,
  output logic                rd_wide,
  output logic [AW-1:0]       rd_addr,
  input  logic                rd_ack,
  input  logic                rd_rvalid,
  input  logic [EW*LANES-1:0] rd_rdata,
  output logic                wr_req,
  output logic                wr_wide,
  output logic [AW-1:0]       wr_addr,
  output logic [EW*LANES-1:0] wr_data,
  output logic [LANES-1:0]    wr_be,
  input  logic                wr_ack
);
  localparam int WW = EW * LANES;
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [1:0] OP_COPY = 2'd0, OP_AXPY = 2'd1, OP_XPAY = 2'd2;
  localparam logic signed [2*EW-1:0] HALF = (2*EW)'(1) <<< (FRAC - 1);
  localparam logic signed [2*EW-1:0] PMAX = (2*EW)'((1 << (EW - 1)) - 1);
  localparam logic signed [2*EW-1:0] PMIN = -PMAX - 1;

  typedef enum logic [1:0] {R_IDLE, R_REQ, R_WAIT, R_FULL} rstate_e;

  function automatic logic [EW-1:0] qmul(input logic [EW-1:0] a, input logic [EW-1:0] b);
    logic signed [2*EW-1:0] p;
    p = ($signed(a) * $signed(b) + HALF) >>> FRAC;
    if (p > PMAX)      qmul = PMAX[EW-1:0];
    else if (p < PMIN) qmul = PMIN[EW-1:0];
    else               qmul = p[EW-1:0];
  endfunction

  function automatic logic [EW-1:0] qadd(input logic [EW-1:0] a, input logic [EW-1:0] b);
    logic signed [EW:0] s;
    s = $signed(a) + $signed(b);
    if (s[EW] != s[EW-1]) qadd = s[EW] ? {1'b1, {(EW-1){1'b0}}} : {1'b0, {(EW-1){1'b1}}};
    else                  qadd = s[EW-1:0];
  endfunction

  rstate_e          r_st;
  logic             r_op;
  logic [LW-1:0]    r_lane, w_lane;
  logic [NW-1:0]    r_idx, c_cnt;
  logic [AW-1:0]    addr_a, addr_b, w_addr;
  logic [WW-1:0]    buf_a, buf_b, comp_res, c_data;
  logic [LANES-1:0] be_m;
  logic             c_full, c_last, run;

  wire             two_src  = op != OP_COPY;
  wire             a_is_j   = op == 2'd3;
  wire [AW-1:0]    base_a   = a_is_j ? base_j : base_x;
  wire [AW-1:0]    stride_a = a_is_j ? stride_j : stride_x;
  wire [AW-1:0]    base_b   = a_is_j ? base_x : base_y;
  wire [AW-1:0]    stride_b = a_is_j ? stride_x : stride_y;
  wire [NW-1:0]    rem      = n - r_idx;
  wire             last_bat = rem <= NW'(LANES);
  wire [NW-1:0]    r_cnt    = last_bat ? rem : NW'(LANES);
  wire             cur_wide = r_op ? (stride_b == AW'(1)) : (stride_a == AW'(1));
  wire             ph_end   = cur_wide || (NW'(r_lane) == r_cnt - NW'(1));
  wire             y_wide   = stride_y == AW'(1);
  wire             w_fire   = c_full && wr_ack;
  wire             w_rel    = w_fire && (y_wide || NW'(w_lane) == c_cnt - NW'(1));
  wire             take     = (r_st == R_FULL) && (!c_full || w_rel);

  assign rd_req  = r_st == R_REQ;
  assign rd_wide = cur_wide;
  assign rd_addr = r_op ? addr_b : addr_a;
  assign busy    = run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_st <= R_IDLE; r_op <= 1'b0; r_lane <= '0; r_idx <= '0;
      addr_a <= '0; addr_b <= '0; buf_a <= '0; buf_b <= '0;
    end else if (start) begin
      r_st <= (n == '0) ? R_IDLE : R_REQ;
      r_op <= 1'b0; r_lane <= '0; r_idx <= '0;
      addr_a <= base_a; addr_b <= base_b;
    end else begin
      case (r_st)
        R_REQ:  if (rd_ack) r_st <= R_WAIT;
        R_WAIT: if (rd_rvalid) begin
          if (cur_wide) begin
            if (r_op) begin buf_b <= rd_rdata; addr_b <= addr_b + AW'(LANES); end
            else      begin buf_a <= rd_rdata; addr_a <= addr_a + AW'(LANES); end
          end else begin
            if (r_op) begin buf_b[r_lane*EW +: EW] <= rd_rdata[EW-1:0]; addr_b <= addr_b + stride_b; end
            else      begin buf_a[r_lane*EW +: EW] <= rd_rdata[EW-1:0]; addr_a <= addr_a + stride_a; end
          end
          if (ph_end) begin
            r_lane <= '0;
            if (!r_op && two_src) begin r_op <= 1'b1; r_st <= R_REQ; end
            else r_st <= R_FULL;
          end else begin
            r_lane <= r_lane + LW'(1);
            r_st   <= R_REQ;
          end
        end
        R_FULL: if (take) begin
          r_op  <= 1'b0;
          r_idx <= r_idx + NW'(LANES);
          r_st  <= last_bat ? R_IDLE : R_REQ;
        end
        default: r_st <= R_IDLE;
      endcase
    end
  end

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      case (op)
        OP_COPY: comp_res[k*EW +: EW] = buf_a[k*EW +: EW];
        OP_AXPY: comp_res[k*EW +: EW] = qadd(qmul(alpha, buf_a[k*EW +: EW]), buf_b[k*EW +: EW]);
        OP_XPAY: comp_res[k*EW +: EW] = qadd(qmul(alpha, buf_b[k*EW +: EW]), buf_a[k*EW +: EW]);
        default: comp_res[k*EW +: EW] = qmul(buf_a[k*EW +: EW], buf_b[k*EW +: EW]);
      endcase
      be_m[k] = NW'(k) < c_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_full <= 1'b0; c_last <= 1'b0; c_cnt <= '0; c_data <= '0;
    end else if (start) begin
      c_full <= 1'b0;
    end else if (take) begin
      c_full <= 1'b1; c_data <= comp_res; c_cnt <= r_cnt; c_last <= last_bat;
    end else if (w_rel) begin
      c_full <= 1'b0;
    end
  end

  assign wr_req  = c_full;
  assign wr_wide = y_wide;
  assign wr_addr = w_addr;
  assign wr_data = y_wide ? c_data : WW'(c_data[w_lane*EW +: EW]);
  assign wr_be   = y_wide ? be_m : LANES'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_lane <= '0; w_addr <= '0; done <= 1'b0; run <= 1'b0;
    end else if (start) begin
      w_lane <= '0; w_addr <= base_y;
      done <= (n == '0); run <= (n != '0);
    end else if (w_fire) begin
      w_addr <= w_addr + (y_wide ? AW'(LANES) : stride_y);
      if (w_rel) begin
        w_lane <= '0;
        if (c_last) begin done <= 1'b1; run <= 1'b0; end
      end else begin
        w_lane <= w_lane + LW'(1);
      end
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack && !start |=> rd_req && $stable(rd_addr) && $stable(rd_wide)); // R9
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_ack && !start |=> wr_req && $stable(wr_addr) && $stable(wr_data) && $stable(wr_be)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req && !wr_req); // R8
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(start) || $past(wr_ack)); // R8
  AST_BE_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> wr_be[0] && (wr_wide || $onehot0(wr_be))); // R7
endmodule

// File: tb/tb_vec_update_unit.sv
module tb_vec_update_unit;
  localparam int EW = 16, L = 4, AW = 16, NW = 16, MEMN = 512;
  localparam int BX = 16, BY = 160, BJ = 320;

  logic clk = 0, rst_n = 0, start = 0;
  logic [1:0] op = 0;
  logic [NW-1:0] n = 0;
  logic [EW-1:0] alpha = 0;
  logic [AW-1:0] stride_x = 1, stride_y = 1, stride_j = 1;
  logic busy, done, rd_req, rd_wide, wr_req, wr_wide;
  logic [AW-1:0] rd_addr, wr_addr;
  logic rd_ack = 0, rd_rvalid = 0, wr_ack = 0;
  logic [EW*L-1:0] rd_rdata = 0, wr_data;
  logic [L-1:0] wr_be;

  always #4 clk = ~clk;

  vec_update_unit #(.EW(EW), .LANES(L), .FRAC(8), .AW(AW), .NW(NW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .n(n), .alpha(alpha),
    .base_x(AW'(BX)), .base_y(AW'(BY)), .base_j(AW'(BJ)),
    .stride_x(stride_x), .stride_y(stride_y), .stride_j(stride_j),
    .busy(busy), .done(done), .rd_req(rd_req), .rd_wide(rd_wide), .rd_addr(rd_addr),
    .rd_ack(rd_ack), .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata),
    .wr_req(wr_req), .wr_wide(wr_wide), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_be(wr_be), .wr_ack(wr_ack));

  logic [EW-1:0] mem [MEMN];
  logic [EW-1:0] expm [MEMN];
  int n_chk = 0, n_bad = 0, rdw = 0, rdn = 0, wrw = 0, wrn = 0;
  bit hung = 0;

  // memory model: random acknowledge delay, random read latency (R9)
  int p_lat = 0; bit rd_pend = 0; logic [AW-1:0] p_addr; bit p_wide;
  initial forever begin
    @(negedge clk);
    rd_rvalid = 0;
    if (rd_pend) begin
      if (p_lat == 0) begin
        rd_rvalid = 1; rd_pend = 0;
        for (int k = 0; k < L; k++) begin
          int a; a = int'(p_addr) + k;
          rd_rdata[k*EW +: EW] = ((p_wide || k == 0) && a < MEMN) ? mem[a] : EW'($urandom);
        end
      end else p_lat--;
    end
    if (rd_ack) rd_ack = 0;
    else if (rd_req && !rd_pend && ($urandom % 3) != 0) begin
      rd_ack = 1; rd_pend = 1; p_addr = rd_addr; p_wide = rd_wide; p_lat = $urandom % 3;
      if (rd_wide) rdw++; else rdn++;
    end
    if (wr_ack) wr_ack = 0;
    else if (wr_req && ($urandom % 3) != 0) begin
      wr_ack = 1;
      if (wr_wide) wrw++; else wrn++;
      for (int k = 0; k < L; k++)
        if (wr_be[k] && int'(wr_addr) + k < MEMN) mem[int'(wr_addr) + k] = wr_data[k*EW +: EW];
    end
  end

  function automatic int clampi(int v);
    return (v > 32767) ? 32767 : (v < -32768) ? -32768 : v;
  endfunction
  function automatic logic [EW-1:0] fmul(logic [EW-1:0] a, logic [EW-1:0] b);
    int p; p = int'($signed(a)) * int'($signed(b));
    return EW'(clampi((p + 128) >>> 8));
  endfunction
  function automatic logic [EW-1:0] fadd(logic [EW-1:0] a, logic [EW-1:0] b);
    return EW'(clampi(int'($signed(a)) + int'($signed(b))));
  endfunction

  task automatic check(bit ok, string req, int act, int exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic fill_mem();
    for (int i = 0; i < MEMN; i++) mem[i] = EW'($urandom);
  endtask

  function automatic int nacc(int cnt, int str);
    return (str == 1) ? (cnt + L - 1) / L : cnt;
  endfunction

  task automatic run_case(int o, int cnt, logic [EW-1:0] al, int sx, int sy, int sj);
    string tag; int cyc; int ew, en, sa, sb;
    if (hung) return;
    tag = (o == 0) ? "R1" : (o == 1) ? "R2" : (o == 2) ? "R3" : "R4";
    for (int i = 0; i < MEMN; i++) expm[i] = mem[i];
    for (int i = 0; i < cnt; i++) begin
      logic [EW-1:0] x, y, j;
      x = mem[BX + i*sx]; y = mem[BY + i*sy]; j = mem[BJ + i*sj];
      case (o)
        0: expm[BY + i*sy] = x;
        1: expm[BY + i*sy] = fadd(fmul(al, x), y);
        2: expm[BY + i*sy] = fadd(fmul(al, y), x);
        default: expm[BY + i*sy] = fmul(j, x);
      endcase
    end
    op = 2'(o); n = NW'(cnt); alpha = al;
    stride_x = AW'(sx); stride_y = AW'(sy); stride_j = AW'(sj);
    rdw = 0; rdn = 0; wrw = 0; wrn = 0;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    if (cnt == 0) check(done == 1 && busy == 0, "R8 empty done", int'(done), 1);
    else          check(done == 0 && busy == 1, "R8 done low after start", int'(done), 0);
    cyc = 0;
    while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
    if (!done) begin
      hung = 1; check(0, "R8 watchdog", 0, 1); return;
    end
    check(wrw + wrn == nacc(cnt, sy), "R8 writes before done", wrw + wrn, nacc(cnt, sy));
    sa = (o == 3) ? sj : sx; sb = (o == 3) ? sx : sy;
    ew = 0; en = 0;
    if (cnt > 0) begin
      if (sa == 1) ew += nacc(cnt, 1); else en += cnt;
      if (o != 0) begin if (sb == 1) ew += nacc(cnt, 1); else en += cnt; end
    end
    check(rdw == ew, "R6 wide reads", rdw, ew);
    check(rdn == en, "R6 single reads", rdn, en);
    check((sy == 1) ? (wrn == 0) : (wrw == 0), "R6 write kind", wrw, wrn);
    for (int i = 0; i < cnt; i++)
      check(mem[BY + i*sy] == expm[BY + i*sy], tag, int'($signed(mem[BY + i*sy])),
            int'($signed(expm[BY + i*sy])));
    begin
      int bad_a; bad_a = -1;
      for (int i = 0; i < MEMN; i++) if (mem[i] != expm[i] && bad_a < 0) bad_a = i;
      check(bad_a < 0, "R7 untouched memory", bad_a, -1);
    end
  endtask

  initial begin
    int unused;
    unused = $urandom(32'd2024);
    fill_mem();
    repeat (3) @(negedge clk);
    check(!busy && !done && !rd_req && !wr_req, "R10 reset state", int'({busy, done, rd_req, wr_req}), 0);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !done && !rd_req && !wr_req, "R10 after release", int'({busy, done, rd_req, wr_req}), 0);

    fill_mem(); run_case(0, 10, 16'h0000, 1, 1, 1);
    fill_mem(); run_case(1, 13, 16'h0180, 1, 2, 1);
    fill_mem(); run_case(2, 9, 16'hFF80, 3, 1, 1);
    fill_mem(); run_case(3, 8, 16'h0000, 1, 1, 1);
    fill_mem(); run_case(0, 1, 16'h0000, 2, 2, 1);
    fill_mem(); run_case(1, 0, 16'h0100, 1, 1, 1);

    fill_mem();
    mem[BJ] = 16'd3;      mem[BX] = 16'd128;
    mem[BJ+1] = -16'sd3;  mem[BX+1] = 16'd128;
    mem[BJ+2] = 16'h7FFF; mem[BX+2] = 16'h7FFF;
    mem[BJ+3] = 16'h8000; mem[BX+3] = 16'h7FFF;
    run_case(3, 4, 16'h0000, 1, 1, 1);
    check(mem[BY] == 16'd2, "R5 tie up positive", int'($signed(mem[BY])), 2);
    check(mem[BY+1] == 16'hFFFF, "R5 tie up negative", int'($signed(mem[BY+1])), -1);
    check(mem[BY+2] == 16'h7FFF, "R5 product clamp high", int'($signed(mem[BY+2])), 32767);
    check(mem[BY+3] == 16'h8000, "R5 product clamp low", int'($signed(mem[BY+3])), -32768);

    fill_mem();
    mem[BX] = 16'h7FFF; mem[BY] = 16'h7FFF;
    run_case(1, 1, 16'h7FFF, 1, 1, 1);
    check(mem[BY] == 16'h7FFF, "R5 sum clamp", int'($signed(mem[BY])), 32767);

    for (int t = 0; t < 10; t++) begin
      int o, c, sx, sy, sj;
      o = $urandom % 4; c = $urandom % 21;
      sx = ($urandom % 2) ? 1 : 1 + $urandom % 3;
      sy = ($urandom % 2) ? 1 : 1 + $urandom % 3;
      sj = ($urandom % 2) ? 1 : 1 + $urandom % 3;
      fill_mem();
      run_case(o, c, EW'($urandom), sx, sy, sj); // R9 random stalls throughout
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule